// File: doc/BRIEF.md
# Dual-Edge Up/Down Counter

This block is a small binary counter driven by two separate count strobes instead of one clock and a direction line. A rising edge on the increment strobe raises the count by one. A rising edge on the decrement strobe lowers it by one. No shared count clock exists anywhere in the block.

Each strobe loads its own shadow register with the neighbour of the current count. A last-edge flag records which strobe fired most recently, and the visible count is whichever shadow register that flag selects. The flag is built from one toggle bit per strobe domain, so each bit has exactly one writer.

An active-high reset clears every register asynchronously. It is typically placed behind an edge-producing front end, such as a quadrature decoder that emits separate step-up and step-down pulses.

Top module: `dual_edge_counter`

## Requirements
- R1: While `rst` is high, `count_o` reads 0 without any strobe edge, and both shadow registers and the last-edge flag are cleared.
- R2: A rising edge on `inc_stb` makes `count_o` equal to its previous value plus one.
- R3: A rising edge on `dec_stb` makes `count_o` equal to its previous value minus one.
- R4: An increment at the all-ones value (15 at the default width of 4) wraps the count to 0.
- R5: A decrement at 0 wraps the count to the all-ones value (15 at the default width).
- R6: The output follows the strobe that fired last, so alternating and repeated increment/decrement sequences track a modulo-2^WIDTH reference.
- R7: Asserting `rst` in the middle of a count clears it at once, and counting resumes from 0 after release.
- R8: With no strobe edge, `count_o` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst | input | 1 | Asynchronous active-high clear |
| inc_stb | input | 1 | Rising edge adds one to the count |
| dec_stb | input | 1 | Rising edge subtracts one from the count |
| count_o | output | WIDTH | Current count (WIDTH = 4 by default) |

## Verification
A stale shadow register or a wrong last-edge flag is visible at the very next strobe. It shows up either as the output jumping back to an older value, or as the next step being taken from that wrong base. A wrong step direction or a broken wrap shows on the output right after the single strobe edge that caused it.

The output is therefore compared after every strobe edge and during idle spans. Reset is also checked while no strobe is toggling, which separates an asynchronous clear from one that waits for an edge.

// File: rtl/udc_pkg.sv
package udc_pkg;
  typedef enum logic {
    SRC_DEC = 1'b0,
    SRC_INC = 1'b1
  } src_e;
endpackage

// File: rtl/udc_shadow.sv
module udc_shadow #(
  parameter int WIDTH     = 4,
  parameter bit INCREMENT = 1'b1
) (
  input  logic             stb_i,
  input  logic             rst,
  input  logic [WIDTH-1:0] cur_i,
  output logic [WIDTH-1:0] q_o
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  logic [WIDTH-1:0] nxt;

  generate
    if (INCREMENT) begin : g_inc
      assign nxt = cur_i + ONE;
    end else begin : g_dec
      assign nxt = cur_i - ONE;
    end
  endgenerate

  always_ff @(posedge stb_i or posedge rst) begin
    if (rst) q_o <= '0;
    else     q_o <= nxt;
  end

  // checker state: at least one strobe edge since the last reset
  logic armed;
  always_ff @(posedge stb_i or posedge rst) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  generate
    if (INCREMENT) begin : g_chk_inc
      AST_UP_STEP: assert property (@(posedge stb_i) disable iff (rst)
        1'b1 |=> (!armed || q_o == $past(cur_i) + ONE)); // R2
    end else begin : g_chk_dec
      AST_DOWN_STEP: assert property (@(posedge stb_i) disable iff (rst)
        1'b1 |=> (!armed || q_o == $past(cur_i) - ONE)); // R3
    end
  endgenerate

  AST_SHADOW_CLEAR: assert property (@(posedge stb_i)
    rst |-> (q_o == '0)); // R1
endmodule

// File: rtl/udc_last_edge.sv
module udc_last_edge (
  input  logic inc_stb,
  input  logic dec_stb,
  input  logic rst,
  output logic inc_last_o
);
  logic tog_inc;
  logic tog_dec;

  // an increment makes the bits differ, a decrement makes them equal
  always_ff @(posedge inc_stb or posedge rst) begin
    if (rst) tog_inc <= 1'b0;
    else     tog_inc <= ~tog_dec;
  end

  always_ff @(posedge dec_stb or posedge rst) begin
    if (rst) tog_dec <= 1'b0;
    else     tog_dec <= tog_inc;
  end

  assign inc_last_o = tog_inc ^ tog_dec;

  AST_FLAG_CLEAR_INC: assert property (@(posedge inc_stb)
    rst |-> (!tog_inc && !tog_dec)); // R1
  AST_FLAG_CLEAR_DEC: assert property (@(posedge dec_stb)
    rst |-> (!tog_inc && !tog_dec)); // R1
endmodule

// File: rtl/dual_edge_counter.sv
module dual_edge_counter #(
  parameter int WIDTH = 4
) (
  input  logic             rst,
  input  logic             inc_stb,
  input  logic             dec_stb,
  output logic [WIDTH-1:0] count_o
);
  import udc_pkg::*;

  logic [WIDTH-1:0] inc_q;
  logic [WIDTH-1:0] dec_q;
  logic             inc_last;
  src_e             src;

  udc_shadow #(.WIDTH(WIDTH), .INCREMENT(1'b1)) u_inc (
    .stb_i (inc_stb),
    .rst   (rst),
    .cur_i (count_o),
    .q_o   (inc_q)
  );

  udc_shadow #(.WIDTH(WIDTH), .INCREMENT(1'b0)) u_dec (
    .stb_i (dec_stb),
    .rst   (rst),
    .cur_i (count_o),
    .q_o   (dec_q)
  );

  udc_last_edge u_flag (
    .inc_stb    (inc_stb),
    .dec_stb    (dec_stb),
    .rst        (rst),
    .inc_last_o (inc_last)
  );

  assign src = src_e'(inc_last);

  always_comb begin
    case (src)
      SRC_INC: count_o = inc_q;
      default: count_o = dec_q;
    endcase
  end
endmodule

// File: tb/dual_edge_counter_tb.sv
module dual_edge_counter_tb;
  localparam int WIDTH = 4;
  localparam int MOD   = 1 << WIDTH;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             inc_stb = 1'b0;
  logic             dec_stb = 1'b0;
  logic [WIDTH-1:0] count_o;

  int    checks = 0;
  int    errors = 0;
  int    expv   = 0;
  int    q_val[$];
  string q_tag[$];
  bit    done = 1'b0;

  always #5 clk = ~clk;

  dual_edge_counter #(.WIDTH(WIDTH)) u_dut (
    .rst     (rst),
    .inc_stb (inc_stb),
    .dec_stb (dec_stb),
    .count_o (count_o)
  );

  task automatic push(input string tag);
    q_val.push_back(expv);
    q_tag.push_back(tag);
  endtask

  // one strobe pulse: high on one negedge, low on the next
  task automatic pulse(input bit up, input string tag);
    @(negedge clk);
    if (up) begin
      inc_stb = 1'b1;
      expv = (expv + 1) % MOD;
    end else begin
      dec_stb = 1'b1;
      expv = (expv + MOD - 1) % MOD;
    end
    push(tag);
    @(negedge clk);
    inc_stb = 1'b0;
    dec_stb = 1'b0;
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      push(tag);
    end
  endtask

  // monitor: compares half a cycle after each driver step
  initial begin
    forever begin
      @(posedge clk);
      if (q_val.size() > 0) begin
        int    v;
        string t;
        v = q_val.pop_front();
        t = q_tag.pop_front();
        checks++;
        if (int'(count_o) != v) begin
          errors++;
          $display("FAIL %s: count_o=%0d expected=%0d", t, count_o, v);
        end
      end
    end
  end

  // watchdog
  initial begin
    int cyc;
    cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 50000) begin
        errors++;
        $display("FAIL watchdog: cycles=%0d expected<=%0d", cyc, 50000);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    // R1: reset state with no strobe edge ever seen
    idle(2, "R1");
    @(negedge clk);
    rst = 1'b0;
    push("R1");

    // R2: repeated increments
    for (int i = 0; i < 5; i++) pulse(1'b1, "R2");
    // R3: repeated decrements
    for (int i = 0; i < 3; i++) pulse(1'b0, "R3");
    // R6: alternating and mixed runs
    for (int i = 0; i < 6; i++) pulse(i[0] == 1'b0, "R6");
    pulse(1'b0, "R6");
    pulse(1'b0, "R6");
    pulse(1'b1, "R6");
    pulse(1'b1, "R6");
    pulse(1'b1, "R6");
    // R8: hold with no edges
    idle(4, "R8");

    // R4: climb to 15, then wrap
    while (expv != MOD - 1) pulse(1'b1, "R2");
    pulse(1'b1, "R4");
    idle(2, "R8");
    // R5: wrap down from 0
    pulse(1'b0, "R5");
    pulse(1'b1, "R4");
    pulse(1'b0, "R5");
    pulse(1'b0, "R3");

    // R7: reset mid-count, checked with no strobe toggling
    for (int i = 0; i < 4; i++) pulse(1'b1, "R6");
    @(negedge clk);
    rst = 1'b1;
    expv = 0;
    push("R7");
    idle(1, "R7");
    @(negedge clk);
    rst = 1'b0;
    push("R7");
    pulse(1'b1, "R7");
    pulse(1'b0, "R7");
    pulse(1'b0, "R5");

    idle(3, "R8");
    while (q_val.size() > 0) @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule